// File: doc/BRIEF.md
# Multi-Width Serial NOR Flash Host Controller

This block is the host side of a serial NOR flash link. One start pulse runs one complete transaction. The block first sends an 8-bit opcode. It then sends between zero and three address bytes, waits a programmable number of dummy clocks, and moves a programmable number of data bytes. The data bytes are either written to the memory or read from it. The opcode and address always go out one bit per clock. The data phase uses one, two or four lanes, chosen at run time.

The block drives the serial clock, which idles low. It also drives an active-low chip select and an active-low memory reset. The 4-bit data bus leaves the block as separate output, output-enable and input vectors, and the pad ring joins them into the bidirectional bus. Two byte-level handshakes carry the data:
- On a write, a one-cycle strobe marks each byte taken from the write-data input.
- On a read, a one-cycle valid pulse marks each byte assembled from the bus.

All state advances only on system clock cycles where the clock enable is high. Each enabled cycle is one half-period of the serial clock.

Top module: `nor_serial_host`

## Requirements
- R1: The data-phase width is decoded from two enables. With `lane_single`=1 the width is 1 bit, whatever `lane_dual` is. With `lane_single`=0 and `lane_dual`=1 it is 2 bits. With both at 0 it is 4 bits.
- R2: The opcode is sent first, and then the `addr_len` least significant bytes of `addr_word`, most significant of those first. Both go MSB first on `dq_out[0]` with `dq_oe`=1101 and `dq_out[3:2]`=11. Lane 1 is released during this time.
- R3: After the address, `dummy_len` serial clock periods follow, with `dq_oe`=0000.
- R4: Write data (`rd_mode`=0) is sent MSB first, one beat per serial clock period.
  - 1-bit width: on lane 0, with `dq_oe`=1101 and lanes 3:2 high.
  - 2-bit width: on lanes 1:0 (lane 1 carries the earlier bit), with `dq_oe`=0011.
  - 4-bit width: on lanes 3:0 (lane 3 carries the earliest bit), with `dq_oe`=1111.
- R5: Read data (`rd_mode`=1) is sampled at each rising serial clock edge.
  - 1-bit width: from lane 1, with `dq_oe`=1100.
  - 2-bit width: from lanes 1:0, with `dq_oe`=0000.
  - 4-bit width: from lanes 3:0, with `dq_oe`=0000.

  Bits are assembled MSB first. Each finished byte appears on `rd_byte` together with a `rd_valid` pulse of one system cycle.
- R6: In a write, `wr_take` pulses for one system cycle each time a byte is loaded from `wr_byte`. That happens once per data byte, and the next byte must then be presented.
- R7: `idle_rdy` is high exactly when no transaction is running. A `start` seen while it is low has no effect.
- R8: `cs_n` is low from the enabled cycle that accepts `start` until the final falling serial clock edge. `sck` is low while idle and toggles once per enabled cycle. A transaction of B beats takes 1+2·B enabled cycles.
- R9: In a cycle with `clk_en`=0, neither `sck`, `cs_n` nor the bus changes.
- R10: `mem_rst_n` is low while `rst_n` is asserted and high in normal operation.
- R11: An address length, dummy count or data count of zero skips that phase entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Advance enable; one enabled cycle is one serial half-period |
| start | input | 1 | Begin a transaction (accepted when idle) |
| lane_single | input | 1 | Width select enable, 1-bit |
| lane_dual | input | 1 | Width select enable, 2-bit |
| rd_mode | input | 1 | 1: read data phase, 0: write data phase |
| cmd_byte | input | 8 | Opcode |
| addr_len | input | 2 | Address bytes to send, 0 to 3 |
| addr_word | input | 24 | Address value |
| dummy_len | input | 4 | Dummy serial clocks, 0 to 14 |
| data_len | input | LEN_W | Data bytes to move |
| wr_byte | input | 8 | Write data byte |
| wr_take | output | 1 | Write byte taken strobe |
| rd_byte | output | 8 | Last byte read |
| rd_valid | output | 1 | Read byte valid pulse |
| idle_rdy | output | 1 | Idle and accepting start |
| mem_rst_n | output | 1 | Memory reset, active low |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dq_out | output | 4 | Bus output values |
| dq_oe | output | 4 | Bus output enables per lane |
| dq_in | input | 4 | Bus input values |

## Verification
In a multi-byte write, one enabled cycle does three things at once. It shifts out the last beat of one byte, loads the next byte from `wr_byte` and raises `wr_take`. The bench therefore changes `wr_byte` only after each strobe. It then compares every captured beat across the byte boundary against the expected lane values, so a lost or doubled load shows up as a wrong beat.

A second collision is a `start` that arrives while a transaction is in flight. The bench raises it for several cycles in mid-transfer. It then checks that the beat count, the cycle count and the idle state after completion are unchanged.

// File: rtl/nsh_pkg.sv
package nsh_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    W_ONE  = 2'd0,
    W_TWO  = 2'd1,
    W_FOUR = 2'd2
  } width_e;

  // control state that does not depend on parameters
  typedef struct packed {
    phase_e      ph;
    logic        sck;
    logic [7:0]  sh;
    logic [7:0]  rx;
    logic [2:0]  beat;
    logic [3:0]  dmy;
    logic [3:0]  dlim;
    width_e      wid;
    logic        rd;
    logic [1:0]  alen;
    logic [23:0] addr;
    logic [7:0]  rbyte;
    logic        take;
    logic        rvld;
  } ctl_t;

  function automatic logic [2:0] beats_m1(width_e w);
    case (w)
      W_ONE:   beats_m1 = 3'd7;
      W_TWO:   beats_m1 = 3'd3;
      default: beats_m1 = 3'd1;
    endcase
  endfunction

  function automatic logic [7:0] tx_adv(width_e w, logic [7:0] s);
    case (w)
      W_ONE:   tx_adv = {s[6:0], 1'b0};
      W_TWO:   tx_adv = {s[5:0], 2'b00};
      default: tx_adv = {s[3:0], 4'b0000};
    endcase
  endfunction

  function automatic logic [7:0] rx_merge(width_e w, logic [7:0] r, logic [3:0] d);
    case (w)
      W_ONE:   rx_merge = {r[6:0], d[1]};
      W_TWO:   rx_merge = {r[5:0], d[1:0]};
      default: rx_merge = {r[3:0], d};
    endcase
  endfunction

  function automatic logic [7:0] addr_pick(logic [23:0] a, logic [1:0] i);
    case (i)
      2'd0:    addr_pick = a[7:0];
      2'd1:    addr_pick = a[15:8];
      default: addr_pick = a[23:16];
    endcase
  endfunction

endpackage

// File: rtl/nsh_lane_dec.sv
module nsh_lane_dec
  import nsh_pkg::*;
(
  input  logic   single_en,
  input  logic   dual_en,
  output width_e width
);

  always_comb begin
    if (single_en)    width = W_ONE;
    else if (dual_en) width = W_TWO;
    else              width = W_FOUR;
  end

endmodule

// File: rtl/nsh_pad_mux.sv
module nsh_pad_mux
  import nsh_pkg::*;
(
  input  phase_e     ph,
  input  width_e     wid,
  input  logic       rd,
  input  logic [7:0] sh,
  output logic [3:0] out,
  output logic [3:0] oe
);

  always_comb begin
    out = 4'b0000;
    oe  = 4'b0000;
    case (ph)
      PH_CMD, PH_ADDR: begin
        oe  = 4'b1101;
        out = {2'b11, 1'b0, sh[7]};
      end
      PH_DATA: begin
        if (rd) begin
          if (wid == W_ONE) begin
            oe  = 4'b1100;
            out = 4'b1100;
          end
        end else begin
          case (wid)
            W_ONE: begin
              oe  = 4'b1101;
              out = {2'b11, 1'b0, sh[7]};
            end
            W_TWO: begin
              oe  = 4'b0011;
              out = {2'b00, sh[7:6]};
            end
            default: begin
              oe  = 4'b1111;
              out = sh[7:4];
            end
          endcase
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/nsh_seq.sv
module nsh_seq
  import nsh_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             start,
  input  width_e           width_i,
  input  logic             rd_i,
  input  logic [7:0]       cmd_i,
  input  logic [1:0]       alen_i,
  input  logic [23:0]      addr_i,
  input  logic [3:0]       dmy_i,
  input  logic [LEN_W-1:0] dlen_i,
  input  logic [7:0]       wr_byte_i,
  input  logic [3:0]       dq_i,
  output phase_e           ph_o,
  output logic             sck_o,
  output logic [7:0]       sh_o,
  output width_e           wid_o,
  output logic             rd_o,
  output logic             take_o,
  output logic [7:0]       rbyte_o,
  output logic             rvld_o
);

  ctl_t             c_q, c_d;
  logic [LEN_W-1:0] byte_q, byte_d;
  logic [LEN_W-1:0] dlen_q, dlen_d;
  phase_e           from_cmd, from_addr, from_dmy, tgt;
  logic             enter;

  // phase that follows each one, skipping empty phases
  always_comb begin
    from_dmy  = (dlen_q != '0)     ? PH_DATA  : PH_IDLE;
    from_addr = (c_q.dlim != 4'd0) ? PH_DUMMY : from_dmy;
    from_cmd  = (c_q.alen != 2'd0) ? PH_ADDR  : from_addr;
  end

  always_comb begin
    c_d      = c_q;
    byte_d   = byte_q;
    dlen_d   = dlen_q;
    c_d.take = 1'b0;
    c_d.rvld = 1'b0;
    enter    = 1'b0;
    tgt      = PH_IDLE;
    if (clk_en) begin
      if (c_q.ph == PH_IDLE) begin
        if (start) begin
          c_d.ph   = PH_CMD;
          c_d.sck  = 1'b0;
          c_d.sh   = cmd_i;
          c_d.beat = 3'd7;
          c_d.wid  = width_i;
          c_d.rd   = rd_i;
          c_d.alen = alen_i;
          c_d.addr = addr_i;
          c_d.dlim = dmy_i;
          dlen_d   = dlen_i;
        end
      end else if (!c_q.sck) begin
        // rising edge: sample read data
        c_d.sck = 1'b1;
        if (c_q.ph == PH_DATA && c_q.rd) begin
          c_d.rx = rx_merge(c_q.wid, c_q.rx, dq_i);
          if (c_q.beat == 3'd0) begin
            c_d.rbyte = c_d.rx;
            c_d.rvld  = 1'b1;
          end
        end
      end else begin
        // falling edge: advance outputs
        c_d.sck = 1'b0;
        case (c_q.ph)
          PH_CMD: begin
            if (c_q.beat == 3'd0) begin
              enter = 1'b1;
              tgt   = from_cmd;
            end else begin
              c_d.sh   = tx_adv(W_ONE, c_q.sh);
              c_d.beat = c_q.beat - 3'd1;
            end
          end
          PH_ADDR: begin
            if (c_q.beat == 3'd0) begin
              if (byte_q == '0) begin
                enter = 1'b1;
                tgt   = from_addr;
              end else begin
                byte_d   = byte_q - 1'b1;
                c_d.beat = 3'd7;
                c_d.sh   = addr_pick(c_q.addr, byte_q[1:0] - 2'd1);
              end
            end else begin
              c_d.sh   = tx_adv(W_ONE, c_q.sh);
              c_d.beat = c_q.beat - 3'd1;
            end
          end
          PH_DUMMY: begin
            if (c_q.dmy == 4'd0) begin
              enter = 1'b1;
              tgt   = from_dmy;
            end else begin
              c_d.dmy = c_q.dmy - 4'd1;
            end
          end
          PH_DATA: begin
            if (c_q.beat == 3'd0) begin
              if (byte_q == '0) begin
                c_d.ph = PH_IDLE;
              end else begin
                byte_d   = byte_q - 1'b1;
                c_d.beat = beats_m1(c_q.wid);
                if (!c_q.rd) begin
                  c_d.sh   = wr_byte_i;
                  c_d.take = 1'b1;
                end
              end
            end else begin
              c_d.sh   = tx_adv(c_q.wid, c_q.sh);
              c_d.beat = c_q.beat - 3'd1;
            end
          end
          default: c_d.ph = PH_IDLE;
        endcase
        if (enter) begin
          c_d.ph = tgt;
          case (tgt)
            PH_ADDR: begin
              byte_d   = LEN_W'(c_q.alen - 2'd1);
              c_d.beat = 3'd7;
              c_d.sh   = addr_pick(c_q.addr, c_q.alen - 2'd1);
            end
            PH_DUMMY: c_d.dmy = c_q.dlim - 4'd1;
            PH_DATA: begin
              byte_d   = dlen_q - 1'b1;
              c_d.beat = beats_m1(c_q.wid);
              if (!c_q.rd) begin
                c_d.sh   = wr_byte_i;
                c_d.take = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q    <= '0;
      byte_q <= '0;
      dlen_q <= '0;
    end else begin
      c_q    <= c_d;
      byte_q <= byte_d;
      dlen_q <= dlen_d;
    end
  end

  assign ph_o    = c_q.ph;
  assign sck_o   = c_q.sck;
  assign sh_o    = c_q.sh;
  assign wid_o   = c_q.wid;
  assign rd_o    = c_q.rd;
  assign take_o  = c_q.take;
  assign rbyte_o = c_q.rbyte;
  assign rvld_o  = c_q.rvld;

endmodule

// File: rtl/nor_serial_host.sv
module nor_serial_host
  import nsh_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             start,
  input  logic             lane_single,
  input  logic             lane_dual,
  input  logic             rd_mode,
  input  logic [7:0]       cmd_byte,
  input  logic [1:0]       addr_len,
  input  logic [23:0]      addr_word,
  input  logic [3:0]       dummy_len,
  input  logic [LEN_W-1:0] data_len,
  input  logic [7:0]       wr_byte,
  output logic             wr_take,
  output logic [7:0]       rd_byte,
  output logic             rd_valid,
  output logic             idle_rdy,
  output logic             mem_rst_n,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       dq_out,
  output logic [3:0]       dq_oe,
  input  logic [3:0]       dq_in
);

  logic [1:0] rsync_q;
  logic       rst_n_s;
  width_e     width_sel, wid_cur;
  phase_e     ph_cur;
  logic [7:0] sh_cur;
  logic       rd_cur;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  nsh_lane_dec u_dec (
    .single_en (lane_single),
    .dual_en   (lane_dual),
    .width     (width_sel)
  );

  nsh_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clk_en    (clk_en),
    .start     (start),
    .width_i   (width_sel),
    .rd_i      (rd_mode),
    .cmd_i     (cmd_byte),
    .alen_i    (addr_len),
    .addr_i    (addr_word),
    .dmy_i     (dummy_len),
    .dlen_i    (data_len),
    .wr_byte_i (wr_byte),
    .dq_i      (dq_in),
    .ph_o      (ph_cur),
    .sck_o     (sck),
    .sh_o      (sh_cur),
    .wid_o     (wid_cur),
    .rd_o      (rd_cur),
    .take_o    (wr_take),
    .rbyte_o   (rd_byte),
    .rvld_o    (rd_valid)
  );

  nsh_pad_mux u_pad (
    .ph  (ph_cur),
    .wid (wid_cur),
    .rd  (rd_cur),
    .sh  (sh_cur),
    .out (dq_out),
    .oe  (dq_oe)
  );

  assign idle_rdy  = (ph_cur == PH_IDLE);
  assign cs_n      = (ph_cur == PH_IDLE);
  assign mem_rst_n = rst_n_s;

endmodule

// File: rtl/nsh_chk.sv
module nsh_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_en,
  input logic       start,
  input logic       idle_rdy,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] dq_oe,
  input logic       rd_valid,
  input logic       wr_take,
  input logic       mem_rst_n
);

  // R8
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R7
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_rdy && start && clk_en) |=> (!cs_n && !idle_rdy));

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R6
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> !wr_take);

  // R6
  take_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (!cs_n && !rd_valid));

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(sck) && $stable(cs_n) && $stable(dq_oe)));

  // R3
  idle_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (dq_oe == 4'b0000));

  // R10
  mem_out_of_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> mem_rst_n);

endmodule

bind nor_serial_host nsh_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .clk_en    (clk_en),
  .start     (start),
  .idle_rdy  (idle_rdy),
  .cs_n      (cs_n),
  .sck       (sck),
  .dq_oe     (dq_oe),
  .rd_valid  (rd_valid),
  .wr_take   (wr_take),
  .mem_rst_n (mem_rst_n)
);

// File: tb/test_nor_serial_host.sv
module test_nor_serial_host;

  logic       clk = 1'b0;
  logic       rst_n, clk_en, start, lane_single, lane_dual, rd_mode;
  logic [7:0] cmd_byte, wr_byte, rd_byte;
  logic [1:0] addr_len;
  logic [23:0] addr_word;
  logic [3:0] dummy_len, dq_out, dq_oe, dq_in;
  logic [7:0] data_len;
  logic       wr_take, rd_valid, idle_rdy, mem_rst_n, sck, cs_n;

  int vecs = 0, bad = 0;
  bit done = 0;

  // bench-side device model state
  int         rises = 0;
  int         mdl_start = 1000, mdl_w = 1;
  logic [3:0] log_out [0:127];
  logic [3:0] log_oe  [0:127];
  logic [7:0] rdat [0:7];
  logic [7:0] wdat [0:7];
  logic [3:0] exp_out [0:127];
  logic [3:0] exp_oe  [0:127];
  logic [7:0] rcv [0:7];

  always #2 clk = ~clk;

  nor_serial_host #(.LEN_W(8)) i_nor_serial_host (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
    .lane_single(lane_single), .lane_dual(lane_dual), .rd_mode(rd_mode),
    .cmd_byte(cmd_byte), .addr_len(addr_len), .addr_word(addr_word),
    .dummy_len(dummy_len), .data_len(data_len), .wr_byte(wr_byte),
    .wr_take(wr_take), .rd_byte(rd_byte), .rd_valid(rd_valid),
    .idle_rdy(idle_rdy), .mem_rst_n(mem_rst_n), .sck(sck), .cs_n(cs_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // model: log the bus at each rising serial clock edge
  always @(posedge sck) begin
    if (rises < 128) begin
      log_out[rises] = dq_out;
      log_oe[rises]  = dq_oe;
    end
    rises = rises + 1;
  end

  // model: present read data after each falling serial clock edge
  always @(negedge sck) begin
    int k, bpb;
    logic [7:0] v;
    if (rises >= mdl_start) begin
      k   = rises - mdl_start;
      bpb = 8 / mdl_w;
      v   = rdat[(k / bpb) % 8] >> (8 - mdl_w * ((k % bpb) + 1));
      case (mdl_w)
        1:       dq_in = {2'b00, v[0], 1'b0};
        2:       dq_in = {2'b00, v[1:0]};
        default: dq_in = v[3:0];
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  // one transaction: build expectations, run it, compare
  task automatic xfer(input logic s_en, input logic d_en, input logic rd,
                      input logic [7:0] cmd, input logic [1:0] al,
                      input logic [23:0] ad, input logic [3:0] dm,
                      input int nb, input bit gap, input bit poke);
    int w, n, beats, busy, got, takes, wi, rises_end;
    bit seen;
    logic [7:0] bv;
    w = s_en ? 1 : (d_en ? 2 : 4);           // R1 decode
    n = 0;
    for (int i = 7; i >= 0; i--) begin       // R2 opcode
      exp_out[n] = {3'b110, cmd[i]}; exp_oe[n] = 4'b1101; n++;
    end
    for (int b = int'(al) - 1; b >= 0; b--)  // R2 low address bytes
      for (int i = 7; i >= 0; i--) begin
        exp_out[n] = {3'b110, ad[8*b+i]}; exp_oe[n] = 4'b1101; n++;
      end
    for (int i = 0; i < int'(dm); i++) begin // R3
      exp_out[n] = 4'b0000; exp_oe[n] = 4'b0000; n++;
    end
    mdl_start = n;
    mdl_w     = w;
    for (int b = 0; b < nb; b++)
      for (int j = 0; j < 8 / w; j++) begin
        bv = wdat[b] >> (8 - w * (j + 1));
        if (rd) begin
          exp_oe[n] = (w == 1) ? 4'b1100 : 4'b0000; exp_out[n] = exp_oe[n];
        end else if (w == 1) begin
          exp_oe[n] = 4'b1101; exp_out[n] = {3'b110, bv[0]};
        end else if (w == 2) begin
          exp_oe[n] = 4'b0011; exp_out[n] = {2'b00, bv[1:0]};
        end else begin
          exp_oe[n] = 4'b1111; exp_out[n] = bv[3:0];
        end
        n++;
      end
    beats = n;

    @(negedge clk);
    rises = 0;
    lane_single = s_en; lane_dual = d_en; rd_mode = rd;
    cmd_byte = cmd; addr_len = al; addr_word = ad; dummy_len = dm;
    data_len = 8'(nb); wr_byte = wdat[0];
    clk_en = 1'b1; start = 1'b1;
    busy = 0; got = 0; takes = 0; wi = 0; seen = 0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (rd_valid) begin
        if (got < 8) rcv[got] = rd_byte;
        got++;
      end
      if (wr_take) begin
        takes++; wi++;
        wr_byte = wdat[wi % 8];
      end
      if (!idle_rdy) begin
        seen = 1;
        start = poke && busy >= 6 && busy < 12;
        busy++;
      end else if (seen) begin
        break;
      end
      clk_en = gap ? ~clk_en : 1'b1;
    end
    start = 1'b0; clk_en = 1'b1;
    rises_end = rises;

    chk(rises_end == beats, "R8", "serial clock periods", rises_end, beats);
    for (int i = 0; i < beats && i < 128; i++) begin
      string tg;
      if (i < 8 + 8 * int'(al))          tg = "R2";
      else if (i < mdl_start)            tg = "R3";
      else                               tg = rd ? "R1 R5" : "R1 R4";
      chk((log_oe[i] == exp_oe[i]) && ((log_out[i] & exp_oe[i]) == (exp_out[i] & exp_oe[i])),
          tg, $sformatf("beat %0d oe/out", i), {log_oe[i], log_out[i]},
          {exp_oe[i], exp_out[i]});
    end
    if (gap) chk(busy == 4 * beats, "R9", "busy clocks, half-rate enable", busy, 4 * beats);
    else     chk(busy == 2 * beats, "R8", "busy clocks, full-rate enable", busy, 2 * beats);
    if (rd) begin
      chk(got == nb, "R5", "bytes read", got, nb);
      for (int b = 0; b < nb && b < 8; b++)
        chk(rcv[b] == rdat[b], "R5", $sformatf("read byte %0d", b), rcv[b], rdat[b]);
    end else begin
      chk(takes == nb, "R6", "write strobes", takes, nb);
      chk(got == 0, "R5", "no read pulses in a write", got, 0);
    end
    if (poke) begin
      repeat (10) @(negedge clk);
      chk(idle_rdy == 1'b1 && cs_n == 1'b1, "R7", "idle after start while busy",
          {idle_rdy, cs_n}, 2'b11);
      chk(rises == rises_end, "R7", "no extra serial clocks", rises, rises_end);
    end
  endtask

  initial begin
    #(4 * 150000);
    vecs++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clk_en = 1'b0; start = 1'b0; lane_single = 1'b1;
    lane_dual = 1'b0; rd_mode = 1'b0; cmd_byte = '0; addr_len = '0;
    addr_word = '0; dummy_len = '0; data_len = '0; wr_byte = '0; dq_in = '0;
    for (int i = 0; i < 8; i++) begin rdat[i] = '0; wdat[i] = '0; end

    repeat (3) @(negedge clk);
    chk(mem_rst_n == 1'b0, "R10", "memory reset during reset", mem_rst_n, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_rst_n == 1'b1, "R10", "memory reset released", mem_rst_n, 1);
    chk(idle_rdy == 1'b1, "R7", "ready after reset", idle_rdy, 1);
    chk(cs_n == 1'b1 && sck == 1'b0, "R8", "select/clock idle", {cs_n, sck}, 2'b10);
    chk(dq_oe == 4'b0000, "R3", "bus released at idle", dq_oe, 0);

    // single-lane read, three address bytes
    rdat[0] = 8'hB4; rdat[1] = 8'h6D;
    xfer(1'b1, 1'b0, 1'b1, 8'hA5, 2'd3, 24'h3C81E7, 4'd0, 2, 1'b0, 1'b0);
    // both enables high selects single lane (R1), with dummy clocks
    wdat[0] = 8'h8B; wdat[1] = 8'h5E; wdat[2] = 8'hC3;
    xfer(1'b1, 1'b1, 1'b0, 8'h02, 2'd3, 24'h00FF10, 4'd2, 3, 1'b0, 1'b0);
    // dual read, two address bytes drop the top byte
    rdat[0] = 8'h9C; rdat[1] = 8'h27;
    xfer(1'b0, 1'b1, 1'b1, 8'h3B, 2'd2, 24'hAB1234, 4'd3, 2, 1'b0, 1'b0);
    // dual write with half-rate enable
    wdat[0] = 8'hEF; wdat[1] = 8'h41;
    xfer(1'b0, 1'b1, 1'b0, 8'hA2, 2'd1, 24'h000055, 4'd0, 2, 1'b1, 1'b0);
    // quad read with half-rate enable
    rdat[0] = 8'hD5; rdat[1] = 8'hD9; rdat[2] = 8'h0F;
    xfer(1'b0, 1'b0, 1'b1, 8'h6B, 2'd1, 24'h0000C7, 4'd6, 3, 1'b1, 1'b0);
    // quad write with no address and no dummy (R11)
    wdat[0] = 8'hB0; wdat[1] = 8'h1E; wdat[2] = 8'h7A; wdat[3] = 8'h96;
    xfer(1'b0, 1'b0, 1'b0, 8'h32, 2'd0, 24'h000000, 4'd0, 4, 1'b0, 1'b0);
    // opcode only (R11), start raised while busy (R7)
    xfer(1'b1, 1'b0, 1'b0, 8'h06, 2'd0, 24'h000000, 4'd0, 0, 1'b0, 1'b1);
    // maximum dummy count, quad read of one byte
    rdat[0] = 8'h3C;
    xfer(1'b0, 1'b0, 1'b1, 8'hEB, 2'd3, 24'h010203, 4'd14, 1, 1'b0, 1'b0);

    finish_run();
  end

endmodule